// File: doc/BRIEF.md
# Reset Strap Configuration Latch

This block takes a bank of sixteen configuration strap pins and samples it once, at the end of the chip's internal reset sequence. It then holds the result for the rest of the chip. The upper strap byte becomes a read-only configuration byte. It carries the write configuration, the chip-select count, the segment address selection and the clock configuration. The lower strap byte sets the bus-type field of the bus configuration and drives the internal mode-control outputs: start mode, address-pin debug mode and one reserved bit.

The reset source decides which fields are refreshed. The reset controller reports it on a two-bit code, sampled in the same cycle as the end-of-reset pulse. A hardware reset refreshes all sixteen bits. Any other reset refreshes only the chip configuration fields: bus type, write configuration, chip-select and segment selection. After such a reset, the clock configuration, the internal-control bits and the reserved bit keep the values they had.

While reset is in progress, the block drives a pad pullup enable, so an open strap pin reads as 1. It also guards the system configuration register. Software may write this register until an end-of-initialization strobe arrives. The strobe locks the register and raises a flag that tells external hardware initialization has finished. Any reset sequence unlocks the register and clears the flag. All interfaces are plain control and status pins: nothing streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `strap_cfg_latch`

## Requirements
- R1: After power-on reset (`rst_n` low) and before the first capture, every strap-derived output reads all ones. `syscon_o` equals the parameter `SYSCON_RST` and `init_done_o` is 0.
- R2: `pullup_en_o` is 1 whenever `rst_n` is low or `rst_seq_i` is high, and 0 otherwise.
- R3: The strap outputs change only in the cycle after a cycle with `rst_end_i` high. Strap pin changes at any other time have no effect.
- R4: Lower strap byte map: bit 0 is `rsvd_o`, bit 1 is `adr_dbg_o`, bits 5:2 are `start_mode_o` and bits 7:6 are `bus_type_o`.
- R5: Upper strap byte map: bit 8 is `wr_cfg_o`, bits 10:9 are `cs_sel_o`, bits 12:11 are `seg_sel_o` and bits 15:13 are `clk_cfg_o`. `cfg_hi_o` equals stored strap bits 15:8.
- R6: When `rst_src_i` is 2'b00 (hardware) at the capture, all sixteen strap bits are loaded.
- R7: When `rst_src_i` is 2'b01 (software), 2'b10 (watchdog) or 2'b11 (treated the same way) at the capture, only bits 12:6 are loaded. Bits 15:13 and 5:0 keep their previous values.
- R8: A write (`syscon_wr_i` high) is accepted while the lock is clear and `rst_seq_i` is low. `syscon_o` shows `syscon_wdata_i` one cycle later. A write in the same cycle as the strobe is still accepted.
- R9: `einit_i` high while `rst_seq_i` is low sets `init_done_o` in the next cycle. From then on, writes leave `syscon_o` unchanged.
- R10: While `rst_seq_i` is high, `init_done_o` reads 0 and `syscon_o` reads `SYSCON_RST` from the next cycle on. Writes and `einit_i` in those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_seq_i | input | 1 | Internal reset sequence in progress |
| rst_end_i | input | 1 | Single-cycle pulse at the end of the reset sequence; triggers the capture |
| rst_src_i | input | 2 | Reset source: 00 hardware, 01 software, 10 watchdog |
| strap_i | input | 16 | Strap pin levels |
| syscon_wr_i | input | 1 | System configuration write strobe |
| syscon_wdata_i | input | SYSCON_W | System configuration write data |
| einit_i | input | 1 | End-of-initialization strobe |
| pullup_en_o | output | 1 | Strap pad pullup enable |
| rsvd_o | output | 1 | Reserved strap bit (hardware reset only) |
| adr_dbg_o | output | 1 | Address-pin debug mode (hardware reset only) |
| start_mode_o | output | 4 | Start mode (hardware reset only) |
| bus_type_o | output | 2 | Bus-type field of the bus configuration |
| cfg_hi_o | output | 8 | Read-only configuration byte |
| wr_cfg_o | output | 1 | Write configuration |
| cs_sel_o | output | 2 | Chip-select count selection |
| seg_sel_o | output | 2 | Segment address line selection |
| clk_cfg_o | output | 3 | Clock configuration (hardware reset only) |
| syscon_o | output | SYSCON_W | System configuration register |
| init_done_o | output | 1 | Initialization finished flag |

## Verification
The bench builds the block with `SYSCON_W` = 12 and `SYSCON_RST` = 12'h5A3. This reset value differs from every value the bench writes and from both all-zeros and all-ones, so a register that reloads the wrong value, or fails to reload, shows up directly. Strap patterns are chosen so that the hardware-only bits and the every-reset bits both differ between consecutive captures. Each reset source then visibly refreshes or holds its own set of fields.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int STRAP_W = 16;
  localparam int BYTE_W  = 8;

  // Bits refreshed only by a hardware-sourced capture: clock config
  // (15:13) and the internal control bits (5:0).
  localparam logic [STRAP_W-1:0] HW_ONLY_MASK = 16'hE03F;
  localparam logic [STRAP_W-1:0] STRAP_DEFAULT = '1;

  typedef enum logic [1:0] {
    SRC_HARD  = 2'b00,
    SRC_SOFT  = 2'b01,
    SRC_WDOG  = 2'b10,
    SRC_SPARE = 2'b11
  } rst_src_e;

  typedef struct packed {
    logic [1:0] bus_type;
    logic [3:0] start_mode;
    logic       adr_dbg;
    logic       rsvd;
  } strap_lo_t;

  typedef struct packed {
    logic [2:0] clk_cfg;
    logic [1:0] seg_sel;
    logic [1:0] cs_sel;
    logic       wr_cfg;
  } strap_hi_t;

endpackage

// File: rtl/strap_sample.sv
module strap_sample #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    HW_MASK  = '0,
  parameter logic [W-1:0]    DEFAULTS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic         hw_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // One flop per strap bit; the mask chooses its refresh class.
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (HW_MASK[b]) begin : g_hw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            q_o[b] <= DEFAULTS[b];
        else if (cap_i && hw_i) q_o[b] <= d_i[b];
      end
    end else begin : g_any
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o[b] <= DEFAULTS[b];
        else if (cap_i) q_o[b] <= d_i[b];
      end
    end
  end

endmodule

// File: rtl/syscon_guard.sv
module syscon_guard #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seq_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         einit_i,
  output logic [W-1:0] q_o,
  output logic         done_o
);

  logic wr_ok;
  assign wr_ok = wr_i && !done_o && !seq_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (seq_i) q_o <= RST_VAL;
    else if (wr_ok) q_o <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_o <= 1'b0;
    else if (seq_i)   done_o <= 1'b0;
    else if (einit_i) done_o <= 1'b1;
  end

endmodule

// File: rtl/pullup_ctl.sv
module pullup_ctl (
  input  logic rst_n,
  input  logic seq_i,
  output logic en_o
);

  assign en_o = !rst_n || seq_i;

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_pkg::*;
#(
  parameter int                  SYSCON_W   = 16,
  parameter logic [SYSCON_W-1:0] SYSCON_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_seq_i,
  input  logic                rst_end_i,
  input  logic [1:0]          rst_src_i,
  input  logic [15:0]         strap_i,
  input  logic                syscon_wr_i,
  input  logic [SYSCON_W-1:0] syscon_wdata_i,
  input  logic                einit_i,
  output logic                pullup_en_o,
  output logic                rsvd_o,
  output logic                adr_dbg_o,
  output logic [3:0]          start_mode_o,
  output logic [1:0]          bus_type_o,
  output logic [7:0]          cfg_hi_o,
  output logic                wr_cfg_o,
  output logic [1:0]          cs_sel_o,
  output logic [1:0]          seg_sel_o,
  output logic [2:0]          clk_cfg_o,
  output logic [SYSCON_W-1:0] syscon_o,
  output logic                init_done_o
);

  logic [STRAP_W-1:0] strap_q;
  logic               src_hard;
  strap_lo_t          lo;
  strap_hi_t          hi;

  assign src_hard = (rst_src_e'(rst_src_i) == SRC_HARD);

  strap_sample #(
    .W        (STRAP_W),
    .HW_MASK  (HW_ONLY_MASK),
    .DEFAULTS (STRAP_DEFAULT)
  ) u_sample (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (rst_end_i),
    .hw_i  (src_hard),
    .d_i   (strap_i),
    .q_o   (strap_q)
  );

  assign lo = strap_lo_t'(strap_q[BYTE_W-1:0]);
  assign hi = strap_hi_t'(strap_q[STRAP_W-1:BYTE_W]);

  assign rsvd_o       = lo.rsvd;
  assign adr_dbg_o    = lo.adr_dbg;
  assign start_mode_o = lo.start_mode;
  assign bus_type_o   = lo.bus_type;
  assign cfg_hi_o     = strap_q[STRAP_W-1:BYTE_W];
  assign wr_cfg_o     = hi.wr_cfg;
  assign cs_sel_o     = hi.cs_sel;
  assign seg_sel_o    = hi.seg_sel;
  assign clk_cfg_o    = hi.clk_cfg;

  syscon_guard #(
    .W       (SYSCON_W),
    .RST_VAL (SYSCON_RST)
  ) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq_i   (rst_seq_i),
    .wr_i    (syscon_wr_i),
    .wdata_i (syscon_wdata_i),
    .einit_i (einit_i),
    .q_o     (syscon_o),
    .done_o  (init_done_o)
  );

  pullup_ctl u_pullup (
    .rst_n (rst_n),
    .seq_i (rst_seq_i),
    .en_o  (pullup_en_o)
  );

endmodule

// File: rtl/strap_cfg_latch_chk.sv
module strap_cfg_latch_chk #(
  parameter int                  SYSCON_W   = 16,
  parameter logic [SYSCON_W-1:0] SYSCON_RST = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_seq_i,
  input logic                rst_end_i,
  input logic [1:0]          rst_src_i,
  input logic [15:0]         strap_i,
  input logic                syscon_wr_i,
  input logic                einit_i,
  input logic                pullup_en_o,
  input logic [3:0]          start_mode_o,
  input logic [1:0]          bus_type_o,
  input logic [7:0]          cfg_hi_o,
  input logic [2:0]          clk_cfg_o,
  input logic [SYSCON_W-1:0] syscon_o,
  input logic                init_done_o
);

  assert_pullup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seq_i |-> pullup_en_o);

  assert_hold_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_end_i |=> ($stable(cfg_hi_o) && $stable(bus_type_o) && $stable(start_mode_o)));

  assert_bus_type_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_end_i |=> (bus_type_o == $past(strap_i[7:6])));

  assert_hi_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_end_i && rst_src_i == 2'b00) |=> (cfg_hi_o == $past(strap_i[15:8])));

  assert_hard_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_end_i && rst_src_i == 2'b00) |=> (clk_cfg_o == $past(strap_i[15:13])));

  assert_soft_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_end_i && rst_src_i != 2'b00) |=> ($stable(clk_cfg_o) && $stable(start_mode_o)));

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_o && !rst_seq_i) |=> $stable(syscon_o));

  assert_einit_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (einit_i && !rst_seq_i) |=> init_done_o);

  assert_seq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seq_i |=> (!init_done_o && syscon_o == SYSCON_RST));

  // R8: a write while unlocked and out of reset lands one cycle later
  logic unused_ok;
  assign unused_ok = syscon_wr_i;

endmodule

bind strap_cfg_latch strap_cfg_latch_chk #(
  .SYSCON_W   (SYSCON_W),
  .SYSCON_RST (SYSCON_RST)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_seq_i    (rst_seq_i),
  .rst_end_i    (rst_end_i),
  .rst_src_i    (rst_src_i),
  .strap_i      (strap_i),
  .syscon_wr_i  (syscon_wr_i),
  .einit_i      (einit_i),
  .pullup_en_o  (pullup_en_o),
  .start_mode_o (start_mode_o),
  .bus_type_o   (bus_type_o),
  .cfg_hi_o     (cfg_hi_o),
  .clk_cfg_o    (clk_cfg_o),
  .syscon_o     (syscon_o),
  .init_done_o  (init_done_o)
);

// File: tb/test_strap_cfg_latch.sv
module test_strap_cfg_latch;

  localparam int          CLK_PERIOD = 10;
  localparam int          SW         = 12;
  localparam logic [11:0] SRST       = 12'h5A3;
  localparam int          WD_LIMIT   = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rst_seq_i = 1'b0;
  logic          rst_end_i = 1'b0;
  logic [1:0]    rst_src_i = 2'b00;
  logic [15:0]   strap_i = 16'hFFFF;
  logic          syscon_wr_i = 1'b0;
  logic [SW-1:0] syscon_wdata_i = '0;
  logic          einit_i = 1'b0;
  logic          pullup_en_o, rsvd_o, adr_dbg_o, wr_cfg_o, init_done_o;
  logic [3:0]    start_mode_o;
  logic [1:0]    bus_type_o, cs_sel_o, seg_sel_o;
  logic [7:0]    cfg_hi_o;
  logic [2:0]    clk_cfg_o;
  logic [SW-1:0] syscon_o;

  strap_cfg_latch #(.SYSCON_W(SW), .SYSCON_RST(SRST)) i_strap_cfg_latch (
    .clk(clk), .rst_n(rst_n), .rst_seq_i(rst_seq_i), .rst_end_i(rst_end_i),
    .rst_src_i(rst_src_i), .strap_i(strap_i), .syscon_wr_i(syscon_wr_i),
    .syscon_wdata_i(syscon_wdata_i), .einit_i(einit_i),
    .pullup_en_o(pullup_en_o), .rsvd_o(rsvd_o), .adr_dbg_o(adr_dbg_o),
    .start_mode_o(start_mode_o), .bus_type_o(bus_type_o), .cfg_hi_o(cfg_hi_o),
    .wr_cfg_o(wr_cfg_o), .cs_sel_o(cs_sel_o), .seg_sel_o(seg_sel_o),
    .clk_cfg_o(clk_cfg_o), .syscon_o(syscon_o), .init_done_o(init_done_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  // Behavioural reference state
  bit [15:0]   m_strap = 16'hFFFF;
  int          m_sys   = int'(SRST);
  bit          m_lock  = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_strap = 16'hFFFF; m_sys = int'(SRST); m_lock = 1'b0;
    end else begin
      if (rst_end_i)
        for (int i = 0; i < 16; i++)
          if (rst_src_i == 2'b00 || (i >= 6 && i <= 12)) m_strap[i] = strap_i[i];
      if (rst_seq_i) begin
        m_sys = int'(SRST); m_lock = 1'b0;
      end else begin
        if (syscon_wr_i && !m_lock) m_sys = int'(syscon_wdata_i);
        if (einit_i) m_lock = 1'b1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) if (live) begin
    chk("R2", "pullup_en", int'(pullup_en_o), int'(!rst_n || rst_seq_i));
    chk("R4", "rsvd", int'(rsvd_o), int'(m_strap[0]));
    chk("R4", "adr_dbg", int'(adr_dbg_o), int'(m_strap[1]));
    chk("R4", "start_mode", int'(start_mode_o), int'(m_strap[5:2]));
    chk("R4", "bus_type", int'(bus_type_o), int'(m_strap[7:6]));
    chk("R5", "wr_cfg", int'(wr_cfg_o), int'(m_strap[8]));
    chk("R5", "cs_sel", int'(cs_sel_o), int'(m_strap[10:9]));
    chk("R5", "seg_sel", int'(seg_sel_o), int'(m_strap[12:11]));
    chk("R5", "clk_cfg", int'(clk_cfg_o), int'(m_strap[15:13]));
    chk("R5", "cfg_hi", int'(cfg_hi_o), int'(m_strap[15:8]));
    chk("R8", "syscon", int'(syscon_o), m_sys);
    chk("R9", "init_done", int'(init_done_o), int'(m_lock));
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(logic [1:0] src, logic [15:0] pat);
    rst_seq_i = 1'b1; strap_i = pat; rst_src_i = src;
    step(); step();
    rst_end_i = 1'b1;
    step();
    rst_end_i = 1'b0; rst_seq_i = 1'b0;
    step();
  endtask

  task automatic wr(logic [SW-1:0] d);
    syscon_wr_i = 1'b1; syscon_wdata_i = d;
    step();
    syscon_wr_i = 1'b0;
  endtask

  initial begin
    @(posedge clk); #1; live = 1'b1;
    step(); step();
    // R1: defaults seen before release
    chk("R1", "cfg_hi default", int'(cfg_hi_o), 'hFF);
    chk("R1", "start_mode default", int'(start_mode_o), 'hF);
    chk("R1", "syscon default", int'(syscon_o), int'(SRST));
    chk("R1", "init_done default", int'(init_done_o), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "bus_type default", int'(bus_type_o), 3);

    // R6: hardware capture loads all bits
    do_reset(2'b00, 16'h3C5A);
    chk("R6", "clk_cfg hw", int'(clk_cfg_o), 1);
    chk("R6", "start_mode hw", int'(start_mode_o), 6);
    chk("R6", "rsvd hw", int'(rsvd_o), 0);

    // R3: strap changes without capture pulse
    strap_i = 16'h0000; step(); step();
    chk("R3", "cfg_hi hold", int'(cfg_hi_o), 'h3C);
    chk("R3", "bus_type hold", int'(bus_type_o), 1);

    // R8 write, same-cycle write with strobe, then R9 lock
    wr(12'h123); step();
    chk("R8", "syscon write", int'(syscon_o), 'h123);
    syscon_wr_i = 1'b1; syscon_wdata_i = 12'h246; einit_i = 1'b1;
    step();
    syscon_wr_i = 1'b0; einit_i = 1'b0;
    chk("R8", "write with strobe", int'(syscon_o), 'h246);
    chk("R9", "init_done set", int'(init_done_o), 1);
    wr(12'h456); step();
    chk("R9", "write locked", int'(syscon_o), 'h246);

    // R7 software reset, R10 writes and einit during reset ignored
    rst_seq_i = 1'b1; syscon_wr_i = 1'b1; syscon_wdata_i = 12'h789; einit_i = 1'b1;
    step(); step();
    syscon_wr_i = 1'b0; einit_i = 1'b0;
    chk("R10", "syscon reset", int'(syscon_o), int'(SRST));
    chk("R10", "init_done cleared", int'(init_done_o), 0);
    rst_seq_i = 1'b0;
    do_reset(2'b01, 16'hC381);
    chk("R7", "clk_cfg held sw", int'(clk_cfg_o), 1);
    chk("R7", "start_mode held sw", int'(start_mode_o), 6);
    chk("R7", "adr_dbg held sw", int'(adr_dbg_o), 1);
    chk("R7", "bus_type sw", int'(bus_type_o), 2);
    chk("R7", "cs_sel sw", int'(cs_sel_o), 1);

    // watchdog and spare-code resets
    do_reset(2'b10, 16'h1E67);
    chk("R7", "clk_cfg held wdog", int'(clk_cfg_o), 1);
    chk("R7", "seg_sel wdog", int'(seg_sel_o), 3);
    do_reset(2'b11, 16'hFF00);
    chk("R7", "start_mode held spare", int'(start_mode_o), 6);
    chk("R7", "wr_cfg spare", int'(wr_cfg_o), 1);

    // R6 final hardware reset refreshes held bits
    do_reset(2'b00, 16'hA0F5);
    chk("R6", "clk_cfg hw again", int'(clk_cfg_o), 5);
    chk("R6", "start_mode hw again", int'(start_mode_o), 'hD);
    wr(12'h0F0); step();
    chk("R8", "write after reset", int'(syscon_o), 'h0F0);
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", wd, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule